// File: doc/BRIEF.md
# Synchronous Burst SRAM with Zero-Turnaround Data Bus

A single-clock static RAM core with a small byte-lane array, built so that reads and writes can follow each other on every clock with no idle cycle on the data bus. Every command input (select, load/continue, write controls, address, burst order) and the write data are captured on the rising clock edge. A run-time mode input chooses the read path. In flow-through mode the array output reaches the data pins straight from the registered address. In pipelined mode it passes through an output register and arrives one cycle later. Write data is expected in the same bus slot that a read in the same position would use. That slot is one edge after the command in flow-through mode and two edges after it in pipelined mode, so the bus direction can change on any cycle.

A load command starts an access at the given address. A continue command steps through a four-word group in linear or interleaved order and repeats the read or write type of the access that started the burst. Writes update only the byte lanes selected by the byte-write enable and the per-lane strobes. The global write input updates every lane. The output enable and the sleep input act on the output drive at once, without waiting for a clock. While sleep is high, commands are ignored and the stored contents are kept.

Top module: `nbt_sram`

## Requirements
- R1: After reset, with no command issued, `dq_drive` is 0 and `dq_out` is 0.
- R2: When `pipe_mode` is 0, a read command captured at clock edge k drives its word on `dq_out` from edge k until edge k+1. The write data of a write command captured at edge k is taken from `wdata` at edge k+1.
- R3: When `pipe_mode` is 1, a read command captured at edge k drives its word from edge k+1 until edge k+2. The write data of a write command captured at edge k is taken at edge k+2.
- R4: A load with `bwe`=1 and `gw`=0 is a write that updates exactly the lanes i where `strb[i]`=1. Lane i is `wdata[8i+7:8i]`. With `strb`=0 no byte changes.
- R5: A load with `gw`=1 writes all four lanes, whatever `bwe` and `strb` are. A load with `gw`=0 and `bwe`=0 is a read.
- R6: Commands can be issued on every cycle in any read/write mix. A read returns the word as left by all earlier commands, including a write issued on the cycle just before it, in both modes.
- R7: A command with `cs`=1 and `load`=0 continues the current burst with the same type and lane mask. Beat n (n counted modulo 4 from 0 at the load) keeps address bits [5:2] of the load address. Its bits [1:0] are (start+n) mod 4 when `burst_linear` was 1 at the load, and start XOR n otherwise. A continue with no burst active is ignored. A cycle with `cs`=0 ends the burst.
- R8: `oe`=0 forces `dq_drive` and `dq_out` to 0 at once, without waiting for a clock edge.
- R9: `sleep`=1 forces `dq_drive` to 0 at once. Commands presented while `sleep` is 1 are ignored, and the stored words are kept.
- R10: `dq_drive` is 1 only during the slot of a read beat. A cycle with `cs`=0 performs no access, even with write controls active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through; change only while idle |
| burst_linear | input | 1 | Burst order captured at a load: 1 = linear, 0 = interleaved |
| cs | input | 1 | Chip select for this cycle's command |
| load | input | 1 | 1 = start an access at `addr`, 0 = continue the burst |
| gw | input | 1 | Global write, all lanes |
| bwe | input | 1 | Byte-write enable, used with `strb` |
| strb | input | 4 | Per-lane write strobes |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data, taken in the write's data slot |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| dq_out | output | 32 | Read data, 0 when not driving |
| dq_drive | output | 1 | Output driver enable |

## Verification
The hardest case is a pipelined read that follows a write to the same word on the very next cycle. At the edge where the output register loads, the array has not yet been written. The read only returns the right word if the committing write's lanes are merged into it. The bench reaches this with back-to-back write-read-write-read runs on a single address, using partial lane masks so that merged and stale lanes are both visible. It also runs bursts that wrap inside their four-word group and continues issued after a deselect. The expected words come from a command-ordered reference array kept by the bench.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  // Width of the in-group burst counter (four-word groups)
  localparam int BURST_BITS = 2;

  // Address offset of burst step 'step' from group start 'start'
  function automatic logic [BURST_BITS-1:0] burst_offset(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] step,
    input logic                  linear
  );
    logic [BURST_BITS-1:0] res;
    if (linear) res = start + step;
    else        res = start ^ step;
    return res;
  endfunction

  // Lane mask of a load command
  function automatic logic [7:0] load_mask(
    input logic       glob,
    input logic       byte_en,
    input logic [7:0] strobes
  );
    logic [7:0] res;
    if (glob)         res = '1;
    else if (byte_en) res = strobes;
    else              res = '0;
    return res;
  endfunction

endpackage

// File: rtl/nbt_burst_seq.sv
module nbt_burst_seq
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              load,
  input  logic              gw,
  input  logic              bwe,
  input  logic [NBYTES-1:0] strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linear,
  output logic              op_valid,
  output logic              op_write,
  output logic [ADDR_W-1:0] op_addr,
  output logic [NBYTES-1:0] op_mask
);
  localparam int HI_LSB = BURST_BITS;

  logic                  act_q, wr_q, lin_q;
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] step_q, step_nx;
  logic [NBYTES-1:0]     mask_q, mask_ld;
  logic                  is_load, is_cont;
  logic [7:0]            strb_w, mask_w;

  assign is_load = cs & load;
  assign is_cont = cs & ~load & act_q;
  assign step_nx = step_q + 1'b1;

  always_comb begin
    strb_w = '0;
    strb_w[NBYTES-1:0] = strb;
  end
  assign mask_w  = load_mask(gw, bwe, strb_w);
  assign mask_ld = mask_w[NBYTES-1:0];

  always_comb begin
    op_valid = 1'b0;
    op_write = 1'b0;
    op_addr  = addr;
    op_mask  = '0;
    if (is_load) begin
      op_valid = 1'b1;
      op_write = gw | bwe;
      op_addr  = addr;
      op_mask  = mask_ld;
    end else if (is_cont) begin
      op_valid = 1'b1;
      op_write = wr_q;
      op_addr  = {base_q[ADDR_W-1:HI_LSB],
                  burst_offset(base_q[HI_LSB-1:0], step_nx, lin_q)};
      op_mask  = mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      lin_q  <= 1'b1;
      base_q <= '0;
      step_q <= '0;
      mask_q <= '0;
    end else if (is_load) begin
      act_q  <= 1'b1;
      wr_q   <= gw | bwe;
      lin_q  <= linear;
      base_q <= addr;
      step_q <= '0;
      mask_q <= mask_ld;
    end else if (is_cont) begin
      step_q <= step_nx;
    end else if (!cs) begin
      act_q  <= 1'b0;
    end
  end

  // R7: a continued beat stays in its group and moves to a new word
  p_burst_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_cont |-> (op_addr[ADDR_W-1:HI_LSB] == $past(op_addr[ADDR_W-1:HI_LSB]))
             && (op_addr[HI_LSB-1:0] != $past(op_addr[HI_LSB-1:0])))
    else $error("burst beat left its group or repeated a word");

endmodule

// File: rtl/nbt_cmd_pipe.sv
module nbt_cmd_pipe #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              op_valid,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [NBYTES-1:0] op_mask,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NBYTES-1:0] mem_mask
);
  logic              s1_v, s1_w, s2_v, s2_w;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [NBYTES-1:0] s1_m, s2_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_w <= 1'b0; s1_a <= '0; s1_m <= '0;
      s2_v <= 1'b0; s2_w <= 1'b0; s2_a <= '0; s2_m <= '0;
    end else begin
      s1_v <= op_valid;
      s1_w <= op_write;
      s1_a <= op_addr;
      s1_m <= op_mask;
      s2_v <= s1_v;
      s2_w <= s1_w;
      s2_a <= s1_a;
      s2_m <= s1_m;
    end
  end

  // Reads always look up the stage-1 address; writes commit in the data slot
  assign rd_req  = s1_v & ~s1_w;
  assign rd_addr = s1_a;

  always_comb begin
    if (pipe_mode) begin
      mem_we   = s2_v & s2_w;
      mem_addr = s2_a;
      mem_mask = s2_m;
    end else begin
      mem_we   = s1_v & s1_w;
      mem_addr = s1_a;
      mem_mask = s1_m;
    end
  end

endmodule

// File: rtl/nbt_byte_array.sv
module nbt_byte_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [NBYTES-1:0]   wmask,
  input  logic [NBYTES*8-1:0] wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [NBYTES*8-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[b]) lane[waddr] <= wdata[8*b +: 8];
    end

    assign rdata[8*b +: 8] = lane[raddr];
  end

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pipe_mode,
  input  logic                rd_req,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NBYTES*8-1:0] arr_data,
  input  logic                mem_we,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [NBYTES-1:0]   mem_mask,
  input  logic [NBYTES*8-1:0] wdata,
  output logic                rd_valid,
  output logic [NBYTES*8-1:0] rd_data
);
  localparam int DATA_W = NBYTES * 8;

  logic              pv_q;
  logic [DATA_W-1:0] out_q, merged;
  logic              hit;

  // A write committing on the same edge as the output-register load
  assign hit = mem_we && (mem_addr == rd_addr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
    assign merged[8*b +: 8] = (hit && mem_mask[b]) ? wdata[8*b +: 8]
                                                   : arr_data[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      out_q <= '0;
    end else begin
      pv_q <= rd_req;
      if (rd_req) out_q <= merged;
    end
  end

  assign rd_valid = pipe_mode ? pv_q  : rd_req;
  assign rd_data  = pipe_mode ? out_q : arr_data;

  // R3: in pipelined mode a looked-up read is presented one edge later
  p_pipe_read_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && $past(rd_req)) |-> rd_valid)
    else $error("pipelined read missed its slot");

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pipe_mode,
  input  logic                burst_linear,
  input  logic                cs,
  input  logic                load,
  input  logic                gw,
  input  logic                bwe,
  input  logic [NBYTES-1:0]   strb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NBYTES*8-1:0] wdata,
  input  logic                oe,
  input  logic                sleep,
  output logic [NBYTES*8-1:0] dq_out,
  output logic                dq_drive
);
  localparam int DATA_W = NBYTES * 8;

  logic              cs_eff;
  logic              op_valid, op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [NBYTES-1:0] op_mask;
  logic              rd_req, mem_we, rd_valid;
  logic [ADDR_W-1:0] rd_addr, mem_addr;
  logic [NBYTES-1:0] mem_mask;
  logic [DATA_W-1:0] arr_data, rd_data;

  // Sleep blocks command capture
  assign cs_eff = cs & ~sleep;

  nbt_burst_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs(cs_eff), .load(load), .gw(gw), .bwe(bwe),
    .strb(strb), .addr(addr), .linear(burst_linear),
    .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr), .op_mask(op_mask)
  );

  nbt_cmd_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr), .op_mask(op_mask),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_mask(mem_mask)
  );

  nbt_byte_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wmask(mem_mask), .wdata(wdata),
    .raddr(rd_addr), .rdata(arr_data)
  );

  nbt_read_path #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .rd_req(rd_req), .rd_addr(rd_addr), .arr_data(arr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_mask(mem_mask), .wdata(wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Asynchronous output gating
  assign dq_drive = rd_valid & oe & ~sleep;
  assign dq_out   = dq_drive ? rd_data : '0;

  // Cycles since reset, for assertions that look two edges back
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R2: flow-through write data is committed one edge after the command
  p_flow_write_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !$past(pipe_mode) && $past(op_valid && op_write))
      |-> mem_we && (mem_addr == $past(op_addr)))
    else $error("flow-through write not committed in its slot");

  // R3: pipelined write data is committed two edges after the command
  p_pipe_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2)
     && $past(op_valid && op_write, 2))
      |-> mem_we && (mem_addr == $past(op_addr, 2)))
    else $error("pipelined write not committed in its slot");

  // R9: no command is accepted while asleep
  p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !op_valid)
    else $error("command accepted during sleep");

  // R10: in flow-through mode the bus is driven only after a read command
  p_idle_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !$past(pipe_mode) && !$past(op_valid && !op_write)) |-> !dq_drive)
    else $error("output driven outside a read slot");

endmodule

// File: tb/nbt_sram_test.sv
module nbt_sram_test;
  localparam int MAXN = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_mode = 1'b0, burst_linear = 1'b1;
  logic        cs = 1'b0, load = 1'b0, gw = 1'b0, bwe = 1'b0;
  logic [3:0]  strb = '0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        oe = 1'b1, sleep = 1'b0;
  logic [31:0] dq_out;
  logic        dq_drive;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nbt_sram uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_linear(burst_linear),
    .cs(cs), .load(load), .gw(gw), .bwe(bwe), .strb(strb), .addr(addr),
    .wdata(wdata), .oe(oe), .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  // Command queue and per-beat expectations
  logic        c_cs[MAXN], c_ld[MAXN], c_gw[MAXN], c_bwe[MAXN], c_lin[MAXN];
  logic [3:0]  c_strb[MAXN];
  logic [5:0]  c_addr[MAXN];
  logic [31:0] c_wd[MAXN];
  logic        b_valid[MAXN], b_wr[MAXN];
  logic [31:0] b_exp[MAXN];
  int          nq = 0;
  logic [31:0] ref_mem[64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add(input logic c, input logic ld, input logic g, input logic be,
                     input logic [3:0] s, input logic [5:0] a, input logic lin,
                     input logic [31:0] wd);
    c_cs[nq] = c; c_ld[nq] = ld; c_gw[nq] = g; c_bwe[nq] = be;
    c_strb[nq] = s; c_addr[nq] = a; c_lin[nq] = lin; c_wd[nq] = wd;
    nq++;
  endtask

  // Reference: commands take effect in issue order
  task automatic build_expect();
    bit act = 0, wr = 0, lin = 1;
    logic [5:0] base = '0;
    logic [1:0] step = '0, off;
    logic [3:0] mask = '0;
    logic [5:0] a;
    for (int j = 0; j < nq; j++) begin
      b_valid[j] = 0; b_wr[j] = 0; b_exp[j] = '0; a = '0;
      if (!c_cs[j]) act = 0;
      else if (c_ld[j]) begin
        act = 1; base = c_addr[j]; step = 0; lin = c_lin[j];
        wr = c_gw[j] | c_bwe[j];
        mask = c_gw[j] ? 4'hF : (c_bwe[j] ? c_strb[j] : 4'h0);
        b_valid[j] = 1; a = base;
      end else if (act) begin
        step = step + 2'd1;
        off = lin ? 2'(base[1:0] + step) : (base[1:0] ^ step);
        a = {base[5:2], off};
        b_valid[j] = 1;
      end
      if (b_valid[j]) begin
        b_wr[j] = wr;
        if (wr) begin
          for (int b = 0; b < 4; b++)
            if (mask[b]) ref_mem[a][8*b +: 8] = c_wd[j][8*b +: 8];
        end else b_exp[j] = ref_mem[a];
      end
    end
  endtask

  task automatic idle_inputs();
    cs = 0; load = 0; gw = 0; bwe = 0; strb = '0; addr = '0;
  endtask

  task automatic run_seq(input string tag);
    int lat;
    lat = pipe_mode ? 2 : 1;
    build_expect();
    for (int t = 0; t < nq + lat + 3; t++) begin
      int j;
      @(negedge clk);
      j = t - lat;
      wdata = 32'hDEAD_0000 | 32'(t);
      if (j >= 0 && j < nq) begin
        if (b_valid[j] && !b_wr[j]) begin
          chk($sformatf("%s drive beat %0d", tag, j), {31'd0, dq_drive}, 32'd1);
          chk($sformatf("%s data beat %0d", tag, j), dq_out, b_exp[j]);
        end else begin
          chk($sformatf("R10 %s no drive beat %0d", tag, j), {31'd0, dq_drive}, 32'd0);
        end
        if (b_valid[j] && b_wr[j]) wdata = c_wd[j];
      end
      if (t < nq) begin
        cs = c_cs[t]; load = c_ld[t]; gw = c_gw[t]; bwe = c_bwe[t];
        strb = c_strb[t]; addr = c_addr[t]; burst_linear = c_lin[t];
      end else idle_inputs();
    end
    nq = 0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return {8'(i), 8'(~i), 8'(i * 3), 8'h5A};
  endfunction

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset drive", {31'd0, dq_drive}, 32'd0);
    chk("R1 reset data", dq_out, 32'd0);
  endtask

  task automatic t_fill_flow();
    pipe_mode = 0;
    for (int i = 0; i < 64; i++) add(1, 1, 1, 0, 4'h0, 6'(i), 1, pat(i));
    for (int i = 0; i < 64; i += 9) add(1, 1, 0, 0, 4'h0, 6'(i), 1, 0);
    add(1, 1, 0, 0, 4'h0, 6'd63, 1, 0);
    run_seq("R5/R2 fill");
  endtask

  task automatic t_rwr(input logic pm);
    pipe_mode = pm;
    add(1, 1, 1, 0, 4'h0, 6'd5, 1, 32'h1111_2222);
    add(1, 1, 0, 0, 4'h0, 6'd5, 1, 0);
    add(1, 1, 0, 1, 4'h6, 6'd5, 1, 32'hAABB_CCDD);
    add(1, 1, 0, 0, 4'h0, 6'd5, 1, 0);
    add(1, 1, 0, 0, 4'h0, 6'd6, 1, 0);
    add(1, 1, 0, 1, 4'h9, 6'd6, 1, 32'h0102_0304);
    add(1, 1, 0, 0, 4'h0, 6'd6, 1, 0);
    add(1, 1, 1, 1, 4'h1, 6'd6, 1, 32'hCAFE_F00D);
    add(1, 1, 0, 0, 4'h0, 6'd6, 1, 0);
    add(0, 1, 1, 0, 4'h0, 6'd6, 1, 32'h0BAD_0BAD);
    add(1, 1, 0, 0, 4'h0, 6'd6, 1, 0);
    run_seq(pm ? "R6/R3 rwr pipe" : "R6/R2 rwr flow");
  endtask

  task automatic t_bytes(input logic pm);
    pipe_mode = pm;
    add(1, 1, 0, 1, 4'h1, 6'd20, 1, 32'h7777_77EE);
    add(1, 1, 0, 0, 4'h0, 6'd20, 1, 0);
    add(1, 1, 0, 1, 4'h0, 6'd20, 1, 32'hFFFF_FFFF);
    add(1, 1, 0, 0, 4'h0, 6'd20, 1, 0);
    add(1, 1, 0, 1, 4'h8, 6'd21, 1, 32'h9900_0000);
    add(1, 1, 0, 0, 4'h0, 6'd21, 1, 0);
    add(1, 1, 1, 0, 4'h0, 6'd22, 1, 32'h1357_9BDF);
    add(1, 1, 0, 0, 4'h0, 6'd22, 1, 0);
    run_seq(pm ? "R4/R5 lanes pipe" : "R4/R5 lanes flow");
  endtask

  task automatic t_burst(input logic pm);
    pipe_mode = pm;
    add(1, 1, 0, 0, 4'h0, 6'h12, 1, 0);
    for (int i = 0; i < 5; i++) add(1, 0, 0, 0, 4'h0, 6'h00, 1, 0);
    add(1, 1, 0, 0, 4'h0, 6'h25, 0, 0);
    for (int i = 0; i < 4; i++) add(1, 0, 0, 0, 4'h0, 6'h3F, 1, 0);
    add(1, 1, 0, 1, 4'h3, 6'h32, 0, 32'hB000_0000);
    for (int i = 1; i < 4; i++) add(1, 0, 0, 0, 4'h0, 6'h00, 1, 32'hB000_0000 | 32'(i * 16'h1111));
    add(1, 1, 0, 0, 4'h0, 6'h30, 1, 0);
    for (int i = 0; i < 3; i++) add(1, 0, 0, 0, 4'h0, 6'h00, 1, 0);
    add(0, 0, 0, 0, 4'h0, 6'h00, 1, 0);
    add(1, 0, 0, 0, 4'h0, 6'h00, 1, 0);
    add(1, 0, 1, 0, 4'h0, 6'h01, 1, 32'hEEEE_EEEE);
    add(1, 1, 0, 0, 4'h0, 6'h01, 1, 0);
    run_seq(pm ? "R7 burst pipe" : "R7 burst flow");
  endtask

  task automatic t_oe();
    pipe_mode = 1;
    @(negedge clk);
    cs = 1; load = 1; addr = 6'd7;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    chk("R8 drive before oe low", {31'd0, dq_drive}, 32'd1);
    chk("R8 data before oe low", dq_out, ref_mem[7]);
    oe = 0;
    #1;
    chk("R8 drive after oe low", {31'd0, dq_drive}, 32'd0);
    chk("R8 data after oe low", dq_out, 32'd0);
    oe = 1;
    #1;
    chk("R8 drive after oe high", {31'd0, dq_drive}, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sleep();
    pipe_mode = 0;
    @(negedge clk);
    cs = 1; load = 1; addr = 6'd3;
    @(negedge clk);
    idle_inputs();
    chk("R9 data before sleep", dq_out, ref_mem[3]);
    sleep = 1;
    #1;
    chk("R9 drive after sleep", {31'd0, dq_drive}, 32'd0);
    @(negedge clk);
    cs = 1; load = 1; gw = 1; addr = 6'd3;
    @(negedge clk);
    idle_inputs();
    wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cs = 1; load = 1; bwe = 1; strb = 4'hF; addr = 6'd4;
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    sleep = 0;
    repeat (2) @(negedge clk);
    add(1, 1, 0, 0, 4'h0, 6'd3, 1, 0);
    add(1, 1, 0, 0, 4'h0, 6'd4, 1, 0);
    run_seq("R9 retained");
  endtask

  initial begin
    t_reset();
    t_fill_flow();
    t_rwr(0);
    t_rwr(1);
    t_bytes(0);
    t_bytes(1);
    t_burst(0);
    t_burst(1);
    t_oe();
    t_sleep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule